// File: doc/BRIEF.md
# Pulsed Line Code Transceiver

This block codes and decodes the bit stream of a shared serial bus for use over an optical or radio link, where a transceiver cannot tell a held level apart from a dark or quiet channel. On transmit, a dominant bit becomes a short low pulse at the start of the bit period and a recessive bit is a steady high level. On receive, the block looks for falling edges inside each bit window instead of sampling the level. A mode input switches the block back to ordinary level coding, where the line follows the bit and the receiver samples a level partway through the window.

The bit-rate generator lives outside. It supplies a prescaled clock enable (`tick`) and a bit-start strobe that falls on a tick. The block supports bit rates up to 1 Mbit/s. In pulsed mode, reception always uses line input 0 and ignores the input selection. An optical transceiver does not hear its own emission, so while the block transmits, the receiver takes its result from the bit being sent (internal loopback) instead of from the line.

Top module: `pulsed_line_xcvr`

## Requirements
- R1: While reset is asserted, and at once when it is asserted: `line_out` = 1, `rx_valid` = 0, `rx_bit` = 1 and `lb_bit` = 1. Reset takes effect asynchronously and releases on the clock.
- R2: In pulsed mode (`pulsed_mode` = 1), a bit start with `tx_en` = 1 and `tx_bit` = 0 drives `line_out` low from the cycle after the strobe for exactly PULSE_TICKS tick periods (PULSE_TICKS × the tick spacing in cycles). The line then returns high for the rest of the bit.
- R3: In pulsed mode, a recessive bit (`tx_bit` = 1) or a window with `tx_en` = 0 keeps `line_out` high for the whole bit.
- R4: In level mode (`pulsed_mode` = 0), `line_out` takes `tx_bit` in the cycle after the bit start when `tx_en` = 1, and 1 otherwise, and holds that value until the next bit start.
- R5: In pulsed mode without transmission, `rx_bit` is 0 for a window in which a falling edge reached the receiver, and 1 for a window without one. The result appears with a one-cycle `rx_valid` pulse in the cycle after the bit start that closes the window.
- R6: In pulsed mode the receiver listens only to `rx_in[0]`. Edges on the input chosen by `in_sel` have no effect.
- R7: `lb_bit` shows the bit sent in the current window (1 when `tx_en` was 0 at its start) from the cycle after the bit start. In pulsed mode, a window in which the block transmits decodes to that bit, and edges on `rx_in[0]` are ignored.
- R8: In level mode, `rx_bit` is the level of `rx_in[in_sel]` taken at the SAMPLE_TICK-th tick after the bit start. Out-of-range `in_sel` values select input 0.
- R9: The coding mode may change only while the block is idle (`tx_en` = 0 in that cycle and the one before). The next bit is then sent and decoded in the new mode, with no stray pulse.
- R10: The first bit start after reset opens a window but produces no `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulsed_mode | input | 1 | 1 = pulsed coding, 0 = level coding |
| tick | input | 1 | Prescaled clock enable |
| bit_start | input | 1 | Start of a bit period, only on a tick |
| tx_en | input | 1 | Block transmits during the bit starting now |
| tx_bit | input | 1 | Bit to send (0 = dominant) |
| rx_in | input | NUM_IN | Raw receive lines |
| in_sel | input | SEL_W | Input chosen by the external source selection (level mode) |
| line_out | output | 1 | Coded line output |
| rx_bit | output | 1 | Recovered bit of the last closed window |
| rx_valid | output | 1 | One-cycle strobe for `rx_bit` |
| lb_bit | output | 1 | Loopback copy of the bit being sent |

## Verification
The assertions assume a well-formed timing source: `bit_start` comes only on a `tick`, never in two back-to-back cycles, and bit periods are longer than the pulse. They also assume the mode changes only while the block is idle. The bench drives `tick` from a fixed divider and raises `bit_start` only on the first tick of each fixed-length bit. It switches the mode only at the start of an idle bit that follows another idle bit. Receive pulses are placed early in a window, and level-mode inputs are held for the whole window, so the synchronizer delay never pushes an edge or a sample into the next window.

// File: rtl/plc_pkg.sv
package plc_pkg;

  typedef enum logic {
    CODE_LEVEL  = 1'b0,
    CODE_PULSED = 1'b1
  } code_e;

  // bit being sent in the current window
  typedef struct packed {
    logic active;   // tx_en seen at the window start
    logic bit_val;  // bit sent, 1 when idle
  } tx_slot_t;

endpackage

// File: rtl/plc_rst_sync.sv
module plc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/plc_tx_encoder.sv
module plc_tx_encoder
  import plc_pkg::*;
#(
  parameter int PULSE_TICKS = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  code_e    code,
  input  logic     tick,
  input  logic     bit_start,
  input  logic     tx_en,
  input  logic     tx_bit,
  output logic     line_out,
  output tx_slot_t slot
);

  localparam int CNT_W = $clog2(PULSE_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_TICKS);

  tx_slot_t         slot_q, slot_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lvl_q, lvl_d;

  always_comb begin
    slot_d = slot_q;
    cnt_d  = cnt_q;
    lvl_d  = lvl_q;
    if (bit_start) begin
      slot_d.active  = tx_en;
      slot_d.bit_val = tx_en ? tx_bit : 1'b1;
      lvl_d          = tx_en ? tx_bit : 1'b1;
      cnt_d          = (code == CODE_PULSED && tx_en && !tx_bit) ? CNT_LOAD : '0;
    end else if (tick && cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '{active: 1'b0, bit_val: 1'b1};
      cnt_q  <= '0;
      lvl_q  <= 1'b1;
    end else begin
      slot_q <= slot_d;
      cnt_q  <= cnt_d;
      lvl_q  <= lvl_d;
    end
  end

  assign line_out = (code == CODE_PULSED) ? (cnt_q == '0) : lvl_q;
  assign slot     = slot_q;

  // R2: the pulse timer never holds more than the programmed length
  a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LOAD);

  // R2: in pulsed mode the line only comes back high on a tick
  a_r2_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (code == CODE_PULSED && $rose(line_out)) |-> $past(tick));

  // R4: the line only drops right after a bit start
  a_r4_fall_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_out) |-> $past(bit_start));

  // R3: no low level while a recessive or idle bit is sent in pulsed mode
  a_r3_recessive_high: assert property (@(posedge clk) disable iff (!rst_n)
    (code == CODE_PULSED && slot_q.bit_val) |-> line_out);

endmodule

// File: rtl/plc_rx_front.sv
module plc_rx_front
  import plc_pkg::*;
#(
  parameter int NUM_IN      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  code_e             code,
  input  logic [NUM_IN-1:0] rx_in,
  input  logic [SEL_W-1:0]  in_sel,
  output logic              lvl,
  output logic              fell
);

  logic                   src;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  // pulsed coding is pinned to input 0
  always_comb begin
    src = rx_in[0];
    if (code == CODE_LEVEL) begin
      for (int i = 1; i < NUM_IN; i++) begin
        if (in_sel == SEL_W'(i)) src = rx_in[i];
      end
    end
  end

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= src;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], src};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign lvl  = sync_q[SYNC_STAGES-1];
  assign fell = prev_q & ~sync_q[SYNC_STAGES-1];

  // R6: with pulsed coding held, the first stage follows input 0 only
  a_r6_input0_only: assert property (@(posedge clk) disable iff (!rst_n)
    (code == CODE_PULSED && $past(code == CODE_PULSED)) |-> sync_q[0] == $past(rx_in[0]));

  // R5: an edge report is a single-cycle event
  a_r5_fell_single: assert property (@(posedge clk) disable iff (!rst_n)
    fell |=> !fell);

endmodule

// File: rtl/plc_rx_decoder.sv
module plc_rx_decoder
  import plc_pkg::*;
#(
  parameter int SAMPLE_TICK = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  code_e    code,
  input  logic     tick,
  input  logic     bit_start,
  input  logic     lvl,
  input  logic     fell,
  input  tx_slot_t slot,
  output logic     rx_bit,
  output logic     rx_valid
);

  localparam int TCNT_W = $clog2(SAMPLE_TICK + 1);
  localparam logic [TCNT_W-1:0] TCNT_MAX = TCNT_W'(SAMPLE_TICK);
  localparam logic [TCNT_W-1:0] TCNT_HIT = TCNT_W'(SAMPLE_TICK - 1);

  logic              open_q, open_d;
  logic              seen_q, seen_d;
  logic [TCNT_W-1:0] tcnt_q, tcnt_d;
  logic              samp_q, samp_d;
  logic              bit_q, bit_d;
  logic              vld_q, vld_d;
  logic              pulsed_bit;

  // edge decision, or the loopback bit while sending
  assign pulsed_bit = slot.active ? slot.bit_val : ~seen_q;

  always_comb begin
    open_d = open_q;
    seen_d = seen_q | fell;
    tcnt_d = tcnt_q;
    samp_d = samp_q;
    bit_d  = bit_q;
    vld_d  = 1'b0;
    if (bit_start) begin
      open_d = 1'b1;
      seen_d = fell;
      tcnt_d = '0;
      samp_d = 1'b1;
      if (open_q) begin
        vld_d = 1'b1;
        bit_d = (code == CODE_PULSED) ? pulsed_bit : samp_q;
      end
    end else if (tick) begin
      if (tcnt_q == TCNT_HIT) samp_d = lvl;
      if (tcnt_q != TCNT_MAX) tcnt_d = tcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      seen_q <= 1'b0;
      tcnt_q <= '0;
      samp_q <= 1'b1;
      bit_q  <= 1'b1;
      vld_q  <= 1'b0;
    end else begin
      open_q <= open_d;
      seen_q <= seen_d;
      tcnt_q <= tcnt_d;
      samp_q <= samp_d;
      bit_q  <= bit_d;
      vld_q  <= vld_d;
    end
  end

  assign rx_bit   = bit_q;
  assign rx_valid = vld_q;

  // R5: the valid strobe lasts one cycle
  a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R10: a result only follows a bit start
  a_r10_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(bit_start));

  // R7: a sending window in pulsed mode decodes to the bit it sent
  a_r7_loopback_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && code == CODE_PULSED && $past(slot.active)) |-> rx_bit == $past(slot.bit_val));

endmodule

// File: rtl/pulsed_line_xcvr.sv
module pulsed_line_xcvr
  import plc_pkg::*;
#(
  parameter int NUM_IN      = 3,
  parameter int PULSE_TICKS = 2,
  parameter int SAMPLE_TICK = 4,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2,
  parameter int SEL_W       = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pulsed_mode,
  input  logic              tick,
  input  logic              bit_start,
  input  logic              tx_en,
  input  logic              tx_bit,
  input  logic [NUM_IN-1:0] rx_in,
  input  logic [SEL_W-1:0]  in_sel,
  output logic              line_out,
  output logic              rx_bit,
  output logic              rx_valid,
  output logic              lb_bit
);

  logic     rst_n_int;
  code_e    code;
  tx_slot_t slot;
  logic     lvl;
  logic     fell;

  assign code = code_e'(pulsed_mode);

  plc_rst_sync #(.STAGES(RST_STAGES)) i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  plc_tx_encoder #(.PULSE_TICKS(PULSE_TICKS)) i_enc (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .code      (code),
    .tick      (tick),
    .bit_start (bit_start),
    .tx_en     (tx_en),
    .tx_bit    (tx_bit),
    .line_out  (line_out),
    .slot      (slot)
  );

  plc_rx_front #(
    .NUM_IN      (NUM_IN),
    .SYNC_STAGES (SYNC_STAGES),
    .SEL_W       (SEL_W)
  ) i_front (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .code   (code),
    .rx_in  (rx_in),
    .in_sel (in_sel),
    .lvl    (lvl),
    .fell   (fell)
  );

  plc_rx_decoder #(.SAMPLE_TICK(SAMPLE_TICK)) i_dec (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .code      (code),
    .tick      (tick),
    .bit_start (bit_start),
    .lvl       (lvl),
    .fell      (fell),
    .slot      (slot),
    .rx_bit    (rx_bit),
    .rx_valid  (rx_valid)
  );

  assign lb_bit = slot.bit_val;

  // R9: coding mode changes only while nothing is being sent
  a_r9_mode_when_idle: assert property (@(posedge clk) disable iff (!rst_n_int)
    !$stable(pulsed_mode) |-> (!tx_en && !$past(tx_en)));

  // R5: a bit start always falls on a tick
  a_r5_start_on_tick: assert property (@(posedge clk) disable iff (!rst_n_int)
    bit_start |-> tick);

  // R5: bit starts are never back to back
  a_r5_start_spacing: assert property (@(posedge clk) disable iff (!rst_n_int)
    bit_start |=> !bit_start);

endmodule

// File: tb/test_pulsed_line_xcvr.sv
`timescale 1ns/1ps
module test_pulsed_line_xcvr;

  localparam int NUM_IN   = 3;
  localparam int PULSE    = 2;
  localparam int SAMPLE   = 4;
  localparam int TDIV     = 4;
  localparam int BIT_CYC  = 8 * TDIV;
  localparam int NVEC     = 15;

  // [7] pulsed [6] tx_en [5] tx_bit [4:3] in_sel [2] input0 dominant
  // [1] selected input dominant [0] expected rx_bit
  localparam logic [7:0] VEC [NVEC] = '{
    8'b1_0_0_00_1_0_0,  // R5 edge on input 0
    8'b1_0_0_00_0_0_1,  // R5 quiet window
    8'b1_0_0_10_0_1_1,  // R6 edge on other input ignored
    8'b1_0_0_01_1_0_0,  // R6 input 0 still heard
    8'b1_1_0_00_0_0_0,  // R7 loopback dominant
    8'b1_1_1_00_1_0_1,  // R7 external edge ignored
    8'b1_1_0_00_1_0_0,  // R7
    8'b1_0_0_00_0_0_1,  // idle
    8'b0_0_0_01_0_1_0,  // R9 to level, R8 input 1 low
    8'b0_0_0_10_1_0_1,  // R8 input 2 high
    8'b0_1_0_00_1_0_0,  // R4 level dominant
    8'b0_1_1_00_0_0_1,  // R4 level recessive
    8'b0_0_0_00_0_0_1,  // idle
    8'b1_0_0_00_0_0_1,  // R9 back to pulsed
    8'b1_0_0_00_1_0_0   // R5
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              pulsed_mode;
  logic              tick;
  logic              bit_start;
  logic              tx_en;
  logic              tx_bit;
  logic [NUM_IN-1:0] rx_in;
  logic [1:0]        in_sel;
  logic              line_out;
  logic              rx_bit;
  logic              rx_valid;
  logic              lb_bit;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pulsed_line_xcvr #(
    .NUM_IN      (NUM_IN),
    .PULSE_TICKS (PULSE),
    .SAMPLE_TICK (SAMPLE)
  ) i_pulsed_line_xcvr (
    .clk         (clk),
    .rst_n       (rst_n),
    .pulsed_mode (pulsed_mode),
    .tick        (tick),
    .bit_start   (bit_start),
    .tx_en       (tx_en),
    .tx_bit      (tx_bit),
    .rx_in       (rx_in),
    .in_sel      (in_sel),
    .line_out    (line_out),
    .rx_bit      (rx_bit),
    .rx_valid    (rx_valid),
    .lb_bit      (lb_bit)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one bit period; checks the previous window's result at its start
  task automatic run_bit(input logic [7:0] v, input bit have_prev, input logic prev_exp,
                         input bit mode_changed);
    int    line_bad = 0;
    int    vld_bad  = 0;
    string lreq;
    logic  exp_line;
    for (int i = 0; i < BIT_CYC; i++) begin
      @(negedge clk);
      pulsed_mode = v[7];
      tick        = (i % TDIV) == 0;
      bit_start   = (i == 0);
      tx_en       = v[6];
      tx_bit      = v[5];
      in_sel      = v[4:3];
      rx_in       = '1;
      if (v[2] && (!v[7] || (i >= 1 && i <= 8))) rx_in[0] = 1'b0;
      if (v[1] && v[4:3] != 2'd0 && (!v[7] || (i >= 1 && i <= 8))) rx_in[v[4:3]] = 1'b0;
      @(posedge clk);
      #1;
      if (v[7]) exp_line = !(v[6] && !v[5] && i < PULSE * TDIV);
      else      exp_line = v[6] ? v[5] : 1'b1;
      if (line_out !== exp_line) line_bad++;
      if (i == 0) begin
        chk(rx_valid === have_prev, have_prev ? "R5" : "R10", rx_valid, have_prev);
        if (have_prev) chk(rx_bit === prev_exp, "R5/R6/R7/R8 decode", rx_bit, prev_exp);
        chk(lb_bit === (v[6] ? v[5] : 1'b1), "R7 lb_bit", lb_bit, v[6] ? v[5] : 1'b1);
      end else if (rx_valid !== 1'b0) begin
        vld_bad++;
      end
    end
    if (mode_changed)          lreq = "R9 line";
    else if (!v[7])            lreq = "R4 line";
    else if (v[6] && !v[5])    lreq = "R2 line";
    else                       lreq = "R3 line";
    chk(line_bad == 0, lreq, line_bad, 0);
    chk(vld_bad == 0, "R5 strobe width", vld_bad, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic prev_exp;
    rst_n       = 1'b0;
    pulsed_mode = 1'b1;
    tick        = 1'b0;
    bit_start   = 1'b0;
    tx_en       = 1'b0;
    tx_bit      = 1'b1;
    rx_in       = '1;
    in_sel      = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(line_out === 1'b1, "R1 line_out", line_out, 1);
    chk(rx_valid === 1'b0, "R1 rx_valid", rx_valid, 0);
    chk(rx_bit === 1'b1, "R1 rx_bit", rx_bit, 1);
    chk(lb_bit === 1'b1, "R1 lb_bit", lb_bit, 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // table walk; the first window gives no result (R10)
    prev_exp = 1'b1;
    for (int k = 0; k < NVEC; k++) begin
      run_bit(VEC[k], k != 0, prev_exp, k != 0 && VEC[k][7] != VEC[k-1][7]);
      prev_exp = VEC[k][0];
    end
    run_bit(8'b1_0_0_00_0_0_1, 1'b1, prev_exp, 1'b0);

    // R1: reset in the middle of a dominant pulse releases the line at once
    @(negedge clk);
    tick = 1'b1; bit_start = 1'b1; tx_en = 1'b1; tx_bit = 1'b0;
    @(posedge clk);
    #1;
    chk(line_out === 1'b0, "R2 pulse start", line_out, 0);
    @(negedge clk);
    tick = 1'b0; bit_start = 1'b0; tx_en = 1'b0; tx_bit = 1'b1;
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    #0.5;
    chk(line_out === 1'b1, "R1 async line_out", line_out, 1);
    chk(lb_bit === 1'b1, "R1 async lb_bit", lb_bit, 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R10 again after a reset, then a dominant window right after
    run_bit(8'b1_0_0_00_1_0_0, 1'b0, 1'b1, 1'b0);
    run_bit(8'b1_0_0_00_0_0_1, 1'b1, 1'b0, 1'b0);
    run_bit(8'b1_0_0_00_0_0_1, 1'b1, 1'b1, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule